// File: doc/BRIEF.md
# Actuator Driver Power Mode Controller

This block is the supervisory state machine of a coil actuator driver. It keeps the driver in one of three modes (shutdown, standby, active) and decides when the output stage may run. A host turns the driver off by holding the serial bus clock low past a timed idle interval. It wakes the driver by releasing that line. It starts the coil by writing a nonzero current code. The analog detectors for temperature, coil short (via the current-limit comparator), coil open, supply undervoltage and overcurrent report to this block as digital levels.

The block drives one-cycle strobes toward the register file. One strobe reloads all defaults, one zeroes the current code after a protective trip, and one marks the clearing of the status flags when the coil starts. The five status flags are kept here and are sticky. Open and short indications count only while the coil is driven at or above a minimum code, because a small current cannot tell those faults apart from a healthy coil.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: In standby or active, the mode becomes shutdown at the clock edge on which `scl_in` has been sampled low for `IDLE_CYCLES` consecutive edges. Any edge that samples `scl_in` high restarts that count.
- R2: In shutdown the mode stays shutdown while `scl_in` is low. The current code and all fault inputs are ignored there, and `status` holds its value.
- R3: In shutdown, an edge that samples `scl_in` high moves to standby, pulses `load_defaults` for one cycle and zeroes `status`.
- R4: In standby with a nonzero code and `flt_therm` low, the next edge enters active, pulses `status_clear` for one cycle and zeroes `status`. In active, a zero code returns to standby on the next edge.
- R5: `sw_rst` in standby or active gives standby on the next edge, with a one-cycle `load_defaults` pulse and zeroed `status`.
- R6: In active, `flt_therm` high, or a qualified open or short, gives standby on the next edge with a one-cycle `code_clear` pulse.
- R7: While `flt_therm` is high, standby is never left for active, whatever the code.
- R8: `flt_open` and `ilim_trip` are ignored (no mode change, no flag) unless the mode is active and the code is at least `DET_MIN` (256).
- R9: Status flags are sticky, with bit 0 overcurrent, bit 1 undervoltage, bit 2 open, bit 3 short and bit 4 thermal. Each sets on its input outside shutdown and holds until a default load or entry to active.
- R10: The mode encoding is 0 shutdown, 1 standby, 2 active, and 3 never occurs. `drv_en` is high exactly when the mode is active.
- R11: After reset the mode is shutdown, and all strobes, `drv_en` and `status` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Level of the serial bus clock line |
| cur_code | input | CODE_W | Current code held in the register file |
| sw_rst | input | 1 | Software reset strobe |
| flt_therm | input | 1 | Over-temperature detector |
| ilim_trip | input | 1 | Current-limit comparator, reported as coil short |
| flt_open | input | 1 | Coil open detector |
| flt_uvlo | input | 1 | Supply undervoltage detector |
| flt_ovc | input | 1 | Overcurrent detector |
| mode | output | 2 | Present mode: 0 shutdown, 1 standby, 2 active |
| drv_en | output | 1 | Output stage enable |
| load_defaults | output | 1 | One-cycle strobe: reload all registers to defaults |
| code_clear | output | 1 | One-cycle strobe: zero the current code |
| status_clear | output | 1 | One-cycle strobe: status flags cleared on coil start |
| status | output | 5 | Sticky fault flags |

## Verification
Every decision lands in registered outputs one edge after the inputs that caused it. A wrong state therefore shows at `mode` and `drv_en` on the very next cycle. A wrong idle count shows only at the end of the idle window, so the bench checks both sides of that boundary: one edge short and exactly on it, and again after a single high sample restarts the count. Flag faults (a lost or spurious bit, clearing at the wrong time) stay visible on `status` until the next start or default load, so they are checked just after the trip and again some cycles later.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int IDLE_CYCLES = 100000,
  parameter int CODE_W      = 10,
  parameter int DET_MIN     = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic [CODE_W-1:0] cur_code,
  input  logic              sw_rst,
  input  logic              flt_therm,
  input  logic              ilim_trip,
  input  logic              flt_open,
  input  logic              flt_uvlo,
  input  logic              flt_ovc,
  output logic [1:0]        mode,
  output logic              drv_en,
  output logic              load_defaults,
  output logic              code_clear,
  output logic              status_clear,
  output logic [4:0]        status
);
  localparam int CW = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [CW-1:0] LIM = CW'(IDLE_CYCLES - 1);

  typedef enum logic [1:0] {M_SHUT = 2'd0, M_STBY = 2'd1, M_ACT = 2'd2} mode_t;

  mode_t          st_q, st_d;
  logic [CW-1:0]  idle_q;
  logic           ld_d, cc_d, sc_d;
  logic           idle_hit, code_nz, det_ok, trip;
  logic [4:0]     set_vec;

  assign code_nz  = |cur_code;
  assign idle_hit = !scl_in && (idle_q == LIM);
  assign det_ok   = (st_q == M_ACT) && (cur_code >= CODE_W'(DET_MIN));
  assign trip     = flt_therm || (det_ok && (ilim_trip || flt_open));
  assign set_vec  = (st_q == M_SHUT) ? 5'd0 :
                    {flt_therm, det_ok & ilim_trip, det_ok & flt_open, flt_uvlo, flt_ovc};

  always_comb begin
    st_d = st_q;
    ld_d = 1'b0;
    cc_d = 1'b0;
    sc_d = 1'b0;
    if (st_q == M_SHUT) begin
      if (scl_in) begin
        st_d = M_STBY;
        ld_d = 1'b1;
      end
    end else if (idle_hit) begin
      st_d = M_SHUT;
    end else if (sw_rst) begin
      st_d = M_STBY;
      ld_d = 1'b1;
    end else if (st_q == M_ACT) begin
      if (trip) begin
        st_d = M_STBY;
        cc_d = 1'b1;
      end else if (!code_nz) begin
        st_d = M_STBY;
      end
    end else if (code_nz && !flt_therm) begin
      st_d = M_ACT;
      sc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= M_SHUT;
      idle_q        <= '0;
      load_defaults <= 1'b0;
      code_clear    <= 1'b0;
      status_clear  <= 1'b0;
      status        <= '0;
    end else begin
      st_q          <= st_d;
      idle_q        <= scl_in ? '0 : ((idle_q == LIM) ? idle_q : idle_q + 1'b1);
      load_defaults <= ld_d;
      code_clear    <= cc_d;
      status_clear  <= sc_d;
      status        <= (ld_d || sc_d) ? 5'd0 : (status | set_vec);
    end
  end

  assign mode   = st_q;
  assign drv_en = (st_q == M_ACT);
endmodule

module pwr_mode_ctrl_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic [CODE_W-1:0] cur_code,
  input logic              flt_therm,
  input logic [1:0]        mode,
  input logic              drv_en,
  input logic              load_defaults,
  input logic              code_clear,
  input logic              status_clear
);
  // R10
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) mode != 2'd3);
  // R4
  act_needs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> ($past(cur_code) != '0));
  // R4
  sclr_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_clear |-> (mode == 2'd2 && $past(mode) == 2'd1));
  // R6
  cclr_from_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_clear |-> (mode == 2'd1 && $past(mode) == 2'd2));
  // R7
  therm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> !$past(flt_therm));
  // R1
  shut_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && $past(mode) != 2'd0) |-> !$past(scl_in));
  // R3
  defaults_to_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_defaults |-> (mode == 2'd1 && !drv_en));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .cur_code(cur_code),
  .flt_therm(flt_therm), .mode(mode), .drv_en(drv_en),
  .load_defaults(load_defaults), .code_clear(code_clear),
  .status_clear(status_clear)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  localparam int IDLE = 20;
  localparam logic [1:0] SH = 2'd0, SB = 2'd1, AC = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b0;
  logic [9:0] code = '0;
  logic sw_rst = 0, therm = 0, ilim = 0, opn = 0, uvlo = 0, ovc = 0;
  logic [1:0] mode;
  logic drv_en, ld, cc, sc;
  logic [4:0] status;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { string tag; logic [10:0] exp; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.IDLE_CYCLES(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .cur_code(code), .sw_rst(sw_rst),
    .flt_therm(therm), .ilim_trip(ilim), .flt_open(opn), .flt_uvlo(uvlo),
    .flt_ovc(ovc), .mode(mode), .drv_en(drv_en), .load_defaults(ld),
    .code_clear(cc), .status_clear(sc), .status(status)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(string tag, logic [1:0] m, logic l, logic c, logic s, logic [4:0] st);
    item_t it;
    it.tag = tag;
    it.exp = {m, (m == AC), l, c, s, st};
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [10:0] act;
        it = q.pop_front();
        act = {mode, drv_en, ld, cc, sc, status};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: got mode=%0d en=%b ld=%b cc=%b sc=%b st=%b, expected mode=%0d en=%b ld=%b cc=%b sc=%b st=%b",
                   it.tag, act[10:9], act[8], act[7], act[6], act[5], act[4:0],
                   it.exp[10:9], it.exp[8], it.exp[7], it.exp[6], it.exp[5], it.exp[4:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1); expect_st("R11", SH, 0, 0, 0, 5'b00000);
    code = 10'd9;
    tick(3); expect_st("R2", SH, 0, 0, 0, 5'b00000);
    code = 10'd0; scl = 1'b1;
    tick(1); expect_st("R3", SB, 1, 0, 0, 5'b00000);
    tick(1); expect_st("R3", SB, 0, 0, 0, 5'b00000);
    code = 10'd5;
    tick(1); expect_st("R4", AC, 0, 0, 1, 5'b00000);
    tick(1); expect_st("R10", AC, 0, 0, 0, 5'b00000);
    code = 10'd0;
    tick(1); expect_st("R4", SB, 0, 0, 0, 5'b00000);
    uvlo = 1'b1;
    tick(1); uvlo = 1'b0; expect_st("R9", SB, 0, 0, 0, 5'b00010);
    tick(2); expect_st("R9", SB, 0, 0, 0, 5'b00010);
    code = 10'd3;
    tick(1); expect_st("R4", AC, 0, 0, 1, 5'b00000);
    ilim = 1'b1; opn = 1'b1;
    tick(1); expect_st("R8", AC, 0, 0, 0, 5'b00000);
    tick(1); expect_st("R8", AC, 0, 0, 0, 5'b00000);
    ilim = 1'b0; opn = 1'b0;
    code = 10'd300; opn = 1'b1;
    tick(1); expect_st("R6", SB, 0, 1, 0, 5'b00100); code = 10'd0; opn = 1'b0;
    tick(1); expect_st("R6", SB, 0, 0, 0, 5'b00100);
    code = 10'd300;
    tick(1); expect_st("R4", AC, 0, 0, 1, 5'b00000);
    ilim = 1'b1;
    tick(1); expect_st("R6", SB, 0, 1, 0, 5'b01000); code = 10'd0; ilim = 1'b0;
    code = 10'd400;
    tick(1); expect_st("R4", AC, 0, 0, 1, 5'b00000);
    therm = 1'b1;
    tick(1); expect_st("R6", SB, 0, 1, 0, 5'b10000); code = 10'd0;
    tick(1); code = 10'd400;
    tick(1); expect_st("R7", SB, 0, 0, 0, 5'b10000);
    tick(2); expect_st("R7", SB, 0, 0, 0, 5'b10000);
    therm = 1'b0;
    tick(1); expect_st("R7", AC, 0, 0, 1, 5'b00000);
    sw_rst = 1'b1;
    tick(1); sw_rst = 1'b0; expect_st("R5", SB, 1, 0, 0, 5'b00000); code = 10'd0;
    code = 10'd7;
    tick(1); expect_st("R4", AC, 0, 0, 1, 5'b00000);
    ovc = 1'b1;
    tick(1); ovc = 1'b0; expect_st("R9", AC, 0, 0, 0, 5'b00001);
    scl = 1'b0;
    tick(IDLE - 1); scl = 1'b1; expect_st("R1", AC, 0, 0, 0, 5'b00001);
    tick(1); scl = 1'b0; expect_st("R1", AC, 0, 0, 0, 5'b00001);
    tick(IDLE - 1); expect_st("R1", AC, 0, 0, 0, 5'b00001);
    tick(1); expect_st("R1", SH, 0, 0, 0, 5'b00001);
    code = 10'd9; uvlo = 1'b1;
    tick(2); expect_st("R2", SH, 0, 0, 0, 5'b00001);
    uvlo = 1'b0; scl = 1'b1;
    tick(1); expect_st("R3", SB, 1, 0, 0, 5'b00000); code = 10'd0;
    tick(1); expect_st("R3", SB, 0, 0, 0, 5'b00000);
    tick(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule